// File: doc/BRIEF.md
# Two-of-Six Track Selector with Low-Momentum Fallback

This block sits after a coincidence matrix that can report up to six high-momentum track candidates in each bunch crossing. Each candidate carries a valid bit, a momentum rank and a position index. The block picks the two candidates with the highest rank and forwards them in two output slots. Each slot uses the same 9-bit record, whichever readout type produced it.

If a crossing has no valid high-momentum candidate, the block forwards the low-momentum records that arrived from the upstream board for that crossing instead. A per-slot flag tells downstream logic which kind of data each slot carries. A crossing's output is either all high-momentum or all fallback, never a mix of both.

The block is a fixed two-register pipeline. Inputs are captured on one clock edge. The selected result is registered on the next edge. The result for every crossing therefore appears exactly two clocks after its inputs were presented.

Top module: `track_pair_picker`

## Requirements
- R1: When at least one candidate is valid, slot 0 carries the valid candidate with the highest rank, and slot 1 carries the highest-ranked valid candidate among the rest.
- R2: When two valid candidates have equal rank, the one with the lower candidate index wins the earlier slot.
- R3: A slot record is {rank, position}: rank in bits 8:6 and position in bits 5:0.
- R4: When no candidate is valid, slot i carries low record i, with slot valid equal to low valid bit i and the high flag at 0.
- R5: When any candidate is valid, the low inputs are ignored. If exactly one candidate is valid, slot 1 is invalid.
- R6: The output for the inputs presented before clock edge n is visible after clock edge n+1.
- R7: While reset (active low) is asserted, every output is zero.
- R8: An invalid slot has a record of all zeros.
- R9: The high flag of a slot is 1 exactly when the slot is valid and carries a candidate from the matrix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| candValid | input | 6 | Valid bit per high-momentum candidate |
| candRank | input | 18 | 3-bit rank per candidate; candidate i in bits 3i+2:3i |
| candPos | input | 36 | 6-bit position per candidate; candidate i in bits 6i+5:6i |
| lowValid | input | 2 | Valid bit per low-momentum record |
| lowRec | input | 18 | 9-bit low-momentum record per slot; slot i in bits 9i+8:9i |
| slotValid | output | 2 | Valid bit per output slot |
| slotHigh | output | 2 | 1 when the slot carries high-momentum data |
| slotRec | output | 18 | 9-bit record per slot; slot i in bits 9i+8:9i |

## Verification
Every crossing is independent, so a wrong internal state cannot stay hidden for long. It shows up at the ports two clocks after the inputs that caused it.

- A faulty ranking shows as the wrong record or the wrong slot order.
- A faulty tie break shows only when equal ranks collide, so the stimulus uses a narrow rank range to make ties frequent.
- A stale or crossed fallback path shows as mixed high flags, or as low records leaking into a crossing that had candidates.

These faults are visible on the exact cycle they occur. The bench compares all outputs against its model on every clock.

// File: rtl/trk_sel_pkg.sv
package trk_sel_pkg;
  localparam int RANK_W   = 3;
  localparam int POS_W    = 6;
  localparam int REC_W    = RANK_W + POS_W;
  localparam int NUM_CAND = 6;
  localparam int NUM_SLOT = 2;
  localparam int IDX_W    = $clog2(NUM_CAND);

  // strobes from the ranking control into the datapath
  typedef struct packed {
    logic             anyHigh;
    logic             firstOk;
    logic [IDX_W-1:0] firstIdx;
    logic             secondOk;
    logic [IDX_W-1:0] secondIdx;
  } pick_strobe_t;
endpackage

// File: rtl/trk_sel_control.sv
module trk_sel_control
  import trk_sel_pkg::*;
#(
  parameter int NCAND = NUM_CAND,
  parameter int RW    = RANK_W
) (
  input  logic [NCAND-1:0]    stgValid,
  input  logic [NCAND*RW-1:0] stgRank,
  output pick_strobe_t        strobe
);
  logic [RW-1:0] bestRank;
  logic [RW-1:0] nextRank;

  always_comb begin
    strobe   = '0;
    bestRank = '0;
    nextRank = '0;
    strobe.anyHigh = |stgValid;
    // strict greater-than keeps the lower index on equal rank
    for (int i = 0; i < NCAND; i++) begin
      if (stgValid[i] && (!strobe.firstOk || stgRank[i*RW +: RW] > bestRank)) begin
        strobe.firstOk  = 1'b1;
        strobe.firstIdx = IDX_W'(i);
        bestRank        = stgRank[i*RW +: RW];
      end
    end
    for (int i = 0; i < NCAND; i++) begin
      if (stgValid[i] && (IDX_W'(i) != strobe.firstIdx) &&
          (!strobe.secondOk || stgRank[i*RW +: RW] > nextRank)) begin
        strobe.secondOk  = 1'b1;
        strobe.secondIdx = IDX_W'(i);
        nextRank         = stgRank[i*RW +: RW];
      end
    end
  end
endmodule

// File: rtl/trk_sel_datapath.sv
module trk_sel_datapath
  import trk_sel_pkg::*;
#(
  parameter int NCAND = NUM_CAND,
  parameter int RW    = RANK_W,
  parameter int PW    = POS_W,
  parameter int NSLOT = NUM_SLOT,
  localparam int RECW = RW + PW
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NCAND-1:0]      candValid,
  input  logic [NCAND*RW-1:0]   candRank,
  input  logic [NCAND*PW-1:0]   candPos,
  input  logic [NSLOT-1:0]      lowValid,
  input  logic [NSLOT*RECW-1:0] lowRec,
  input  pick_strobe_t          strobe,
  output logic [NCAND-1:0]      stgValid,
  output logic [NCAND*RW-1:0]   stgRank,
  output logic [NSLOT-1:0]      slotValid,
  output logic [NSLOT-1:0]      slotHigh,
  output logic [NSLOT*RECW-1:0] slotRec
);
  logic [NCAND*PW-1:0]   stgPos;
  logic [NSLOT-1:0]      stgLowValid;
  logic [NSLOT*RECW-1:0] stgLowRec;

  // stage 1: capture the crossing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stgValid    <= '0;
      stgRank     <= '0;
      stgPos      <= '0;
      stgLowValid <= '0;
      stgLowRec   <= '0;
    end else begin
      stgValid    <= candValid;
      stgRank     <= candRank;
      stgPos      <= candPos;
      stgLowValid <= lowValid;
      stgLowRec   <= lowRec;
    end
  end

  // per-slot source selection
  logic [NSLOT-1:0]       pickOk;
  logic [NSLOT*IDX_W-1:0] pickIdx;
  assign pickOk  = {strobe.secondOk, strobe.firstOk};
  assign pickIdx = {strobe.secondIdx, strobe.firstIdx};

  // stage 2: register the chosen pair
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [IDX_W-1:0] idx;
    logic [RECW-1:0]  highRec;
    assign idx     = pickIdx[s*IDX_W +: IDX_W];
    assign highRec = {stgRank[idx*RW +: RW], stgPos[idx*PW +: PW]};

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotValid[s]              <= 1'b0;
        slotHigh[s]               <= 1'b0;
        slotRec[s*RECW +: RECW]   <= '0;
      end else if (strobe.anyHigh) begin
        slotValid[s]              <= pickOk[s];
        slotHigh[s]               <= pickOk[s];
        slotRec[s*RECW +: RECW]   <= pickOk[s] ? highRec : '0;
      end else begin
        slotValid[s]              <= stgLowValid[s];
        slotHigh[s]               <= 1'b0;
        slotRec[s*RECW +: RECW]   <= stgLowValid[s] ? stgLowRec[s*RECW +: RECW] : '0;
      end
    end
  end
endmodule

// File: rtl/track_pair_picker.sv
module track_pair_picker
  import trk_sel_pkg::*;
#(
  parameter int NCAND = NUM_CAND,
  parameter int RW    = RANK_W,
  parameter int PW    = POS_W,
  parameter int NSLOT = NUM_SLOT,
  localparam int RECW = RW + PW
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NCAND-1:0]      candValid,
  input  logic [NCAND*RW-1:0]   candRank,
  input  logic [NCAND*PW-1:0]   candPos,
  input  logic [NSLOT-1:0]      lowValid,
  input  logic [NSLOT*RECW-1:0] lowRec,
  output logic [NSLOT-1:0]      slotValid,
  output logic [NSLOT-1:0]      slotHigh,
  output logic [NSLOT*RECW-1:0] slotRec
);
  pick_strobe_t          strobe;
  logic [NCAND-1:0]      stgValid;
  logic [NCAND*RW-1:0]   stgRank;

  trk_sel_control #(.NCAND(NCAND), .RW(RW)) u_ctrl (
    .stgValid (stgValid),
    .stgRank  (stgRank),
    .strobe   (strobe)
  );

  trk_sel_datapath #(.NCAND(NCAND), .RW(RW), .PW(PW), .NSLOT(NSLOT)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .candValid (candValid),
    .candRank  (candRank),
    .candPos   (candPos),
    .lowValid  (lowValid),
    .lowRec    (lowRec),
    .strobe    (strobe),
    .stgValid  (stgValid),
    .stgRank   (stgRank),
    .slotValid (slotValid),
    .slotHigh  (slotHigh),
    .slotRec   (slotRec)
  );
endmodule

// File: rtl/trk_sel_checker.sv
module trk_sel_checker (
  input logic        clk,
  input logic        rstN,
  input logic [5:0]  candValid,
  input logic [1:0]  lowValid,
  input logic [1:0]  slotValid,
  input logic [1:0]  slotHigh,
  input logic [17:0] slotRec
);
  logic [1:0] sinceReset;
  always_ff @(posedge clk) begin
    if (!rstN) sinceReset <= '0;
    else if (sinceReset != 2'd3) sinceReset <= sinceReset + 2'd1;
  end

  p_reset_quiet_r7: assert property (@(posedge clk)
    !rstN |=> (slotValid == 2'b00 && slotHigh == 2'b00 && slotRec == '0));

  p_flag_needs_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((slotHigh & ~slotValid) == 2'b00));

  p_no_mix_r5: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid == 2'b11) |-> (slotHigh[0] == slotHigh[1]));

  p_rank_order_r1: assert property (@(posedge clk) disable iff (!rstN)
    (slotHigh == 2'b11) |-> (slotRec[8:6] >= slotRec[17:15]));

  p_invalid_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!slotValid[1] |-> slotRec[17:9] == '0) and (!slotValid[0] |-> slotRec[8:0] == '0));

  p_high_path_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset >= 2'd2 && $past(candValid, 2) != '0) |-> slotHigh[0]);

  p_fallback_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset >= 2'd2 && $past(candValid, 2) == '0) |->
      (slotHigh == 2'b00 && slotValid == $past(lowValid, 2)));
endmodule

bind track_pair_picker trk_sel_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .candValid (candValid),
  .lowValid  (lowValid),
  .slotValid (slotValid),
  .slotHigh  (slotHigh),
  .slotRec   (slotRec)
);

// File: tb/sim_track_pair_picker.sv
`timescale 1ns/1ps
module sim_track_pair_picker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  candValid = '0;
  logic [17:0] candRank = '0;
  logic [35:0] candPos = '0;
  logic [1:0]  lowValid = '0;
  logic [17:0] lowRec = '0;
  logic [1:0]  slotValid, slotHigh;
  logic [17:0] slotRec;

  always #4 clk = ~clk;  // 125 MHz

  track_pair_picker u0 (
    .clk(clk), .rstN(rstN), .candValid(candValid), .candRank(candRank),
    .candPos(candPos), .lowValid(lowValid), .lowRec(lowRec),
    .slotValid(slotValid), .slotHigh(slotHigh), .slotRec(slotRec)
  );

  int compared = 0;
  int mismatched = 0;

  // two-entry expected pipeline
  logic [1:0]  expV [2];
  logic [1:0]  expH [2];
  logic [17:0] expR [2];
  string       expTag [2];

  // behavioural reference: plain search over integers
  task automatic model(output logic [1:0] v, output logic [1:0] h, output logic [17:0] r);
    int best = -1, next = -1;
    v = '0; h = '0; r = '0;
    for (int i = 0; i < 6; i++)
      if (candValid[i] && (best < 0 || int'(candRank[3*i +: 3]) > int'(candRank[3*best +: 3]))) best = i;
    for (int i = 0; i < 6; i++)
      if (candValid[i] && i != best &&
          (next < 0 || int'(candRank[3*i +: 3]) > int'(candRank[3*next +: 3]))) next = i;
    if (best >= 0) begin
      v[0] = 1; h[0] = 1; r[8:0] = {candRank[3*best +: 3], candPos[6*best +: 6]};
      if (next >= 0) begin
        v[1] = 1; h[1] = 1; r[17:9] = {candRank[3*next +: 3], candPos[6*next +: 6]};
      end
    end else begin
      v = lowValid;
      for (int s = 0; s < 2; s++) if (lowValid[s]) r[9*s +: 9] = lowRec[9*s +: 9];
    end
  endtask

  task automatic compareNow();
    compared++;
    if (slotValid !== expV[1] || slotHigh !== expH[1] || slotRec !== expR[1]) begin
      mismatched++;
      $display("FAIL %s: valid/high/rec got %b/%b/%h expected %b/%b/%h",
               expTag[1], slotValid, slotHigh, slotRec, expV[1], expH[1], expR[1]);
    end
  endtask

  // one crossing: compare, shift model pipe, apply next inputs
  task automatic step(input logic [5:0] v, input logic [17:0] rk, input logic [35:0] ps,
                      input logic [1:0] lv, input logic [17:0] lr, input string tag);
    @(negedge clk);
    compareNow();
    expV[1] = expV[0]; expH[1] = expH[0]; expR[1] = expR[0]; expTag[1] = expTag[0];
    candValid = v; candRank = rk; candPos = ps; lowValid = lv; lowRec = lr;
    model(expV[0], expH[0], expR[0]);
    expTag[0] = tag;
  endtask

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      expV[k] = '0; expH[k] = '0; expR[k] = '0; expTag[k] = "R7 reset";
    end
    repeat (4) begin @(negedge clk); compareNow(); end   // R7 outputs zero in reset
    rstN = 1'b1;
    // R3 single candidate field placement
    step(6'b000100, 18'o000500, {6'd0, 6'd0, 6'd0, 6'd42, 6'd0, 6'd0}, 2'b11, 18'h1ffff, "R3/R5");
    // R1 ordering with distinct ranks
    step(6'b111111, {3'd1,3'd6,3'd2,3'd7,3'd3,3'd0}, {6'd5,6'd4,6'd3,6'd2,6'd1,6'd0}, 2'b00, '0, "R1");
    // R2 all equal ranks: indices 0 and 1 win
    step(6'b111111, {6{3'd4}}, {6'd60,6'd50,6'd40,6'd30,6'd20,6'd10}, 2'b00, '0, "R2");
    // R2 tie between indices 3 and 5 for top
    step(6'b101010, {3'd5,3'd0,3'd5,3'd0,3'd2,3'd0}, {6'd9,6'd8,6'd7,6'd6,6'd5,6'd4}, 2'b01, 18'h00abc, "R2");
    // R4 fallback with both low records, then one, then none
    step(6'b000000, {6{3'd7}}, '1, 2'b11, {9'h1a5, 9'h0c3}, "R4");
    step(6'b000000, '0, '0, 2'b10, {9'h155, 9'h0aa}, "R4/R8");
    step(6'b000000, '0, '0, 2'b00, 18'h3ffff, "R8");
    // R6 back-to-back alternating crossings
    step(6'b000001, 18'o000007, 36'd17, 2'b11, 18'h12345, "R6/R9");
    step(6'b000000, '0, '0, 2'b01, 18'h00111, "R6");
    step(6'b100000, 18'o300000, {6'd33, 30'd0}, 2'b10, 18'h3f000, "R6/R5");
    // random crossings with narrow ranks for frequent ties
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] v;
      logic [17:0] rk;
      v = ($urandom % 4 == 0) ? 6'b0 : 6'($urandom);
      for (int i = 0; i < 6; i++) rk[3*i +: 3] = 3'($urandom % 3) + 3'd3;
      step(v, rk, {$urandom, 4'($urandom)}, 2'($urandom), 18'($urandom), "R1/R2/R4");
    end
    // R7 reset mid-run clears outputs
    @(negedge clk); compareNow();
    rstN = 1'b0;
    for (int k = 0; k < 2; k++) begin
      expV[k] = '0; expH[k] = '0; expR[k] = '0; expTag[k] = "R7 reset";
    end
    candValid = '1;
    @(negedge clk);
    expV[1] = '0; expH[1] = '0; expR[1] = '0;
    compareNow();
    @(negedge clk); compareNow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule